// File: doc/BRIEF.md
# SAR ADC Serial Host Controller with Busy-Flag Readout

This block is the host side of a 16-bit successive-approximation converter whose serial data line also acts as an end-of-conversion flag. A start request latches a 14-bit configuration word and a readback-enable bit. The block then raises the convert strobe and holds it high for a short fixed time. It lowers the strobe again and keeps it low while it watches the data line. The converter releases that line at the start of a conversion, and a pull-up holds it high. When the converter drives the line low, the conversion is complete.

After that low level, one serial frame runs with the clock idling high (SPI mode 3). The new configuration word goes out MSB first on the first 14 rising clock edges. The host captures the 16-bit result MSB first on the falling edges. When readback is enabled, the frame also captures the 14-bit configuration echo. The frame always ends with one more falling edge, which makes the converter release the data line so that the next busy flag can be seen.

A timeout guards the wait for the ready flag. The result is delivered with a one-cycle valid pulse.

Top module: `sar_host_ctrl`

## Requirements
- R1: In idle, a high `start_i` at a clock edge makes `cnv_o` rise one cycle later. `cnv_o` stays high for exactly CNV_HIGH cycles and then stays low until the next accepted start.
- R2: `busy_o` is high from an accepted start until the frame ends or a timeout occurs. A `start_i` seen while `busy_o` is high produces no extra conversion and does not change the configuration that is sent.
- R3: No SCK edge occurs before `sdo_i` has been seen low after `cnv_o` falls.
- R4: If `sdo_i` is still high CONV_CYC+MARGIN cycles after `cnv_o` rises, `err_o` rises, `busy_o` falls and no `result_valid_o` pulse is produced. The next accepted start clears `err_o`.
- R5: `sck_o` is high whenever `busy_o` is low. Each SCK phase inside a frame lasts SCK_HALF system cycles.
- R6: `cfg_i` is sent on `din_o` MSB first, with bit 13 at rising edge 1 and bit 0 at rising edge 14. `din_o` never changes at a rising SCK edge.
- R7: `result_o` holds the 16 bits seen on `sdo_i` just before falling edges 2 to 17, with the first bit as the MSB.
- R8: With `rb_en_i` low at the start, the frame has exactly 17 falling edges and `cfg_echo_o` is 0. With it high, the frame has 31 falling edges and `cfg_echo_o` holds the bits sampled just before falling edges 18 to 31, MSB first.
- R9: `result_valid_o` is a single-cycle pulse in the cycle in which SCK returns high after the last falling edge. `result_o` and `cfg_echo_o` hold their values until the next frame ends.
- R10: `cnv_o` stays low during the whole serial frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion request |
| cfg_i | input | 14 | Configuration word to send in the frame |
| rb_en_i | input | 1 | Capture the configuration echo in this frame |
| cnv_o | output | 1 | Convert strobe to the converter |
| sck_o | output | 1 | Serial clock, idles high |
| din_o | output | 1 | Serial data to the converter |
| sdo_i | input | 1 | Serial data and ready flag from the converter (pulled up) |
| busy_o | output | 1 | A request is in progress |
| result_valid_o | output | 1 | One-cycle pulse when a new result is available |
| result_o | output | 16 | Captured conversion result |
| cfg_echo_o | output | 14 | Captured configuration echo, or 0 |
| err_o | output | 1 | Ready-flag timeout, held until the next accepted start |

## Verification
With the defaults, the results fall due at these points:
- `cnv_o` is seen high one cycle after the start edge and stays high for CNV_HIGH cycles.
- On a timeout, `err_o` appears CONV_CYC+MARGIN cycles after `cnv_o` rose.
- Inside a frame, every SCK phase lasts SCK_HALF cycles.
- `result_valid_o` arrives 2·N·SCK_HALF cycles after the frame begins, where N is 17 or 31.

The bench drives inputs and samples outputs on the falling system clock edge. A converter model detects SCK edges one system cycle late. Because of that delay it never changes SDO in the same cycle in which the host samples it.

The strobe width, the SCK phase lengths and the timeout latency are counted cycle by cycle. The frame results are compared once the valid pulse appears, with the model's edge counters checked at that moment.

// File: rtl/sar_host_pkg.sv
package sar_host_pkg;
  localparam int CFG_W = 14;
  localparam int RES_W = 16;
  localparam int RX_W  = RES_W + CFG_W;

  typedef enum logic [1:0] {ST_IDLE, ST_CNV, ST_WAIT, ST_FRAME} st_e;

  // falling SCK edges in one frame: data bits, optional echo, one release edge
  function automatic int frame_falls(input logic rb);
    return RES_W + (rb ? CFG_W : 0) + 1;
  endfunction

  function automatic int wait_limit(input int conv, input int margin);
    return conv + margin;
  endfunction

  function automatic logic [RES_W-1:0] pick_result(input logic [RX_W-1:0] d, input logic rb);
    return rb ? d[RX_W-1:CFG_W] : d[RES_W-1:0];
  endfunction

  function automatic logic [CFG_W-1:0] pick_echo(input logic [RX_W-1:0] d, input logic rb);
    return rb ? d[CFG_W-1:0] : '0;
  endfunction
endpackage

// File: rtl/sar_sck_gen.sv
module sar_sck_gen #(
  parameter int HALF = 2,
  parameter int FW   = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  output logic          sck_o,
  output logic          fall_o,
  output logic          rise_o,
  output logic [FW-1:0] falls_o
);
  localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [HW-1:0] half_q;
  logic          tick;

  assign tick   = run_i && (half_q == HW'(HALF - 1));
  assign fall_o = tick && sck_o;
  assign rise_o = tick && !sck_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q  <= '0;
      sck_o   <= 1'b1;
      falls_o <= '0;
    end else if (!run_i) begin
      half_q  <= '0;
      sck_o   <= 1'b1;
      falls_o <= '0;
    end else if (tick) begin
      half_q <= '0;
      sck_o  <= ~sck_o;
      if (sck_o) falls_o <= falls_o + 1'b1;
    end else begin
      half_q <= half_q + 1'b1;
    end
  end
endmodule

// File: rtl/sar_din_tx.sv
module sar_din_tx #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  input  logic         shift_i,
  output logic         din_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sh_q <= '0;
    else if (load_i)  sh_q <= word_i;
    else if (shift_i) sh_q <= {sh_q[W-2:0], 1'b0};
  end

  assign din_o = sh_q[W-1];
endmodule

// File: rtl/sar_sdo_rx.sv
module sar_sdo_rx #(
  parameter int W = 30
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         shift_i,
  input  logic         sdo_i,
  output logic [W-1:0] data_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_o <= '0;
    else if (clr_i)   data_o <= '0;
    else if (shift_i) data_o <= {data_o[W-2:0], sdo_i};
  end
endmodule

// File: rtl/sar_host_ctrl.sv
module sar_host_ctrl
  import sar_host_pkg::*;
#(
  parameter int SCK_HALF = 2,
  parameter int CNV_HIGH = 4,
  parameter int CONV_CYC = 550,
  parameter int MARGIN   = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             rb_en_i,
  output logic             cnv_o,
  output logic             sck_o,
  output logic             din_o,
  input  logic             sdo_i,
  output logic             busy_o,
  output logic             result_valid_o,
  output logic [RES_W-1:0] result_o,
  output logic [CFG_W-1:0] cfg_echo_o,
  output logic             err_o
);
  localparam int LIMIT = wait_limit(CONV_CYC, MARGIN);
  localparam int TMO_W = $clog2(LIMIT + 1);
  localparam int CH_W  = $clog2(CNV_HIGH + 1);
  localparam int FW    = $clog2(frame_falls(1'b1) + 1);

  st_e              state_q;
  logic [TMO_W-1:0] tmo_q;
  logic [CH_W-1:0]  hi_q;
  logic             rb_q;
  logic [RX_W-1:0]  rx_data;

  // named internal events
  logic          start_acc, fall_ev, rise_ev, frame_done, timeout_hit, shift_ev;
  logic [FW-1:0] falls, frame_n;

  assign start_acc   = (state_q == ST_IDLE) && start_i;
  assign frame_n     = FW'(frame_falls(rb_q));
  assign frame_done  = rise_ev && (falls == frame_n);
  assign timeout_hit = (state_q == ST_WAIT) && sdo_i && (tmo_q == TMO_W'(LIMIT - 1));
  assign shift_ev    = fall_ev && (falls != '0);
  assign busy_o      = (state_q != ST_IDLE);

  sar_sck_gen #(.HALF(SCK_HALF), .FW(FW)) u_sck (
    .clk(clk), .rst_n(rst_n), .run_i(state_q == ST_FRAME),
    .sck_o(sck_o), .fall_o(fall_ev), .rise_o(rise_ev), .falls_o(falls)
  );

  sar_din_tx #(.W(CFG_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .load_i(start_acc), .word_i(cfg_i),
    .shift_i(shift_ev), .din_o(din_o)
  );

  sar_sdo_rx #(.W(RX_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr_i(start_acc), .shift_i(shift_ev),
    .sdo_i(sdo_i), .data_o(rx_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q        <= ST_IDLE;
      tmo_q          <= '0;
      hi_q           <= '0;
      rb_q           <= 1'b0;
      cnv_o          <= 1'b0;
      err_o          <= 1'b0;
      result_valid_o <= 1'b0;
      result_o       <= '0;
      cfg_echo_o     <= '0;
    end else begin
      result_valid_o <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_CNV;
          cnv_o   <= 1'b1;
          hi_q    <= '0;
          tmo_q   <= '0;
          rb_q    <= rb_en_i;
          err_o   <= 1'b0;
        end
        ST_CNV: begin
          tmo_q <= tmo_q + 1'b1;
          if (hi_q == CH_W'(CNV_HIGH - 1)) begin
            cnv_o   <= 1'b0;
            state_q <= ST_WAIT;
          end else begin
            hi_q <= hi_q + 1'b1;
          end
        end
        ST_WAIT: begin
          tmo_q <= tmo_q + 1'b1;
          if (!sdo_i) begin
            state_q <= ST_FRAME;
          end else if (timeout_hit) begin
            err_o   <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_FRAME: if (frame_done) begin
          state_q        <= ST_IDLE;
          result_valid_o <= 1'b1;
          result_o       <= pick_result(rx_data, rb_q);
          cfg_echo_o     <= pick_echo(rx_data, rb_q);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_host_ctrl_chk.sv
module sar_host_ctrl_chk #(
  parameter int FW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cnv_o,
  input logic          sck_o,
  input logic          din_o,
  input logic          busy_o,
  input logic          result_valid_o,
  input logic          err_o,
  input logic          fall_ev,
  input logic          frame_done,
  input logic [FW-1:0] falls,
  input logic [FW-1:0] frame_n
);
  AST_CNV_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnv_o) |-> !$past(busy_o)); // R2
  AST_CNV_LOW_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_o |-> !cnv_o); // R10
  AST_SCK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> sck_o); // R5
  AST_DIN_STABLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck_o) |-> $stable(din_o)); // R6
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid_o |=> !result_valid_o); // R9
  AST_ERR_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> (!busy_o && !result_valid_o)); // R4
  AST_FALL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    fall_ev |-> (falls < frame_n)); // R8
  AST_DONE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (result_valid_o && sck_o && !busy_o)); // R9
endmodule

bind sar_host_ctrl sar_host_ctrl_chk #(.FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnv_o(cnv_o), .sck_o(sck_o), .din_o(din_o),
  .busy_o(busy_o), .result_valid_o(result_valid_o), .err_o(err_o),
  .fall_ev(fall_ev), .frame_done(frame_done), .falls(falls), .frame_n(frame_n)
);

// File: tb/tb_sar_host_ctrl.sv
`timescale 1ns/1ps
module tb_sar_host_ctrl;
  localparam int SCK_HALF = 2;
  localparam int CNV_HIGH = 4;
  localparam int CONV_CYC = 550;
  localparam int MARGIN   = 50;
  localparam int LIMIT    = CONV_CYC + MARGIN;
  localparam int MDL_CONV = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [13:0] cfg_i = '0;
  logic rb_en_i = 1'b0;
  logic cnv_o, sck_o, din_o, sdo_i, busy_o, result_valid_o, err_o;
  logic [15:0] result_o;
  logic [13:0] cfg_echo_o;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sar_host_ctrl #(.SCK_HALF(SCK_HALF), .CNV_HIGH(CNV_HIGH), .CONV_CYC(CONV_CYC),
                  .MARGIN(MARGIN)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cfg_i(cfg_i), .rb_en_i(rb_en_i),
    .cnv_o(cnv_o), .sck_o(sck_o), .din_o(din_o), .sdo_i(sdo_i), .busy_o(busy_o),
    .result_valid_o(result_valid_o), .result_o(result_o), .cfg_echo_o(cfg_echo_o),
    .err_o(err_o)
  );

  // converter model: edges of CNV/SCK detected one system cycle late
  bit mdl_on = 1'b1, mdl_rb = 1'b0;
  logic [15:0] mdl_data = '0;
  logic [13:0] mdl_cfg = 14'h0000, mdl_cfg_conv = '0, mdl_sh = '0;
  logic mdl_z = 1'b1, mdl_d = 1'b0, mdl_wait = 1'b0;
  logic cnv_p = 1'b0, sck_p = 1'b1;
  int mdl_cnt = 0, rises = 0, falls = 0, hiz_at = 0, cnv_rises = 0;
  bit early_edge = 1'b0, cnv_in_frame = 1'b0;

  assign sdo_i = mdl_z ? 1'b1 : mdl_d;

  always @(posedge clk) begin
    cnv_p <= cnv_o;
    sck_p <= sck_o;
    if (cnv_o && !cnv_p) begin
      mdl_wait <= 1'b1; mdl_cnt <= 0; mdl_z <= 1'b1;
      rises <= 0; falls <= 0; hiz_at <= 0;
      mdl_cfg_conv <= mdl_cfg;
      cnv_rises <= cnv_rises + 1;
    end else if (mdl_wait) begin
      mdl_cnt <= mdl_cnt + 1;
      if (mdl_on && mdl_cnt == MDL_CONV - 1) begin
        mdl_wait <= 1'b0; mdl_z <= 1'b0; mdl_d <= 1'b0;
      end
    end
    if (sck_o != sck_p) begin
      if (mdl_wait) early_edge <= 1'b1;
      if (cnv_o) cnv_in_frame <= 1'b1;
    end
    if (sck_p && !sck_o) begin
      automatic int f = falls + 1;
      falls <= f;
      if (f <= 16) mdl_d <= mdl_data[16-f];
      else if (mdl_rb && f <= 30) mdl_d <= mdl_cfg_conv[30-f];
      else begin
        mdl_z <= 1'b1;
        if (hiz_at == 0) hiz_at <= f;
      end
    end
    if (!sck_p && sck_o) begin
      automatic int r = rises + 1;
      rises <= r;
      if (r <= 14) mdl_sh <= {mdl_sh[12:0], din_o};
      if (r == 14) mdl_cfg <= {mdl_sh[12:0], din_o};
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic kick(input logic [13:0] c, input bit rb);
    @(negedge clk);
    start_i = 1'b1; cfg_i = c; rb_en_i = rb; mdl_rb = rb;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_valid(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (result_valid_o) begin seen = 1'b1; break; end
    end
  endtask

  task automatic t_reset;
    chk(cnv_o == 1'b0, "R1 cnv at reset", cnv_o, 0);
    chk(sck_o == 1'b1, "R5 sck idle at reset", sck_o, 1);
    chk(busy_o == 1'b0, "R2 busy at reset", busy_o, 0);
    chk(result_valid_o == 1'b0, "R9 valid at reset", result_valid_o, 0);
    chk(err_o == 1'b0, "R4 err at reset", err_o, 0);
  endtask

  // strobe width, SCK phase widths, plain 17-edge frame
  task automatic t_plain(input logic [13:0] c, input logic [15:0] d);
    bit seen;
    int hi = 0, low_run = 0, bad_phase = 0, vcnt = 0;
    mdl_data = d; early_edge = 1'b0; cnv_in_frame = 1'b0;
    @(negedge clk);
    start_i = 1'b1; cfg_i = c; rb_en_i = 1'b0; mdl_rb = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    chk(cnv_o == 1'b1, "R1 cnv one cycle after start", cnv_o, 1);
    while (cnv_o) begin hi++; @(negedge clk); end
    chk(hi == CNV_HIGH, "R1 cnv high width", hi, CNV_HIGH);
    for (int i = 0; i < 2000; i++) begin
      if (!sck_o) low_run++;
      else begin
        if (low_run != 0 && low_run != SCK_HALF) bad_phase++;
        low_run = 0;
      end
      if (result_valid_o) begin vcnt++; break; end
      @(negedge clk);
    end
    seen = (vcnt == 1);
    chk(seen, "R9 valid pulse seen", vcnt, 1);
    chk(bad_phase == 0, "R5 sck low phase width", bad_phase, 0);
    chk(sck_o == 1'b1, "R9 sck high at valid", sck_o, 1);
    chk(result_o == d, "R7 result", result_o, d);
    chk(cfg_echo_o == 14'h0, "R8 echo zero without readback", cfg_echo_o, 0);
    @(negedge clk);
    chk(falls == 17, "R8 seventeen falling edges", falls, 17);
    chk(hiz_at == 17, "R8 release on edge 17", hiz_at, 17);
    chk(mdl_cfg == c, "R6 config written", mdl_cfg, c);
    chk(result_valid_o == 1'b0, "R9 valid single cycle", result_valid_o, 0);
    chk(result_o == d, "R9 result held", result_o, d);
    chk(early_edge == 1'b0, "R3 no sck edge before ready", early_edge, 0);
    chk(cnv_in_frame == 1'b0, "R10 cnv low in frame", cnv_in_frame, 0);
  endtask

  task automatic t_readback(input logic [13:0] c, input logic [15:0] d);
    bit seen;
    logic [13:0] prev;
    prev = mdl_cfg;
    mdl_data = d;
    kick(c, 1'b1);
    wait_valid(seen);
    chk(seen, "R8 readback frame valid", seen, 1);
    chk(result_o == d, "R7 result with readback", result_o, d);
    chk(cfg_echo_o == prev, "R8 echo of config in effect", cfg_echo_o, prev);
    @(negedge clk);
    chk(falls == 31, "R8 thirty-one falling edges", falls, 31);
    chk(hiz_at == 31, "R8 release on edge 31", hiz_at, 31);
    chk(mdl_cfg == c, "R6 config written in readback frame", mdl_cfg, c);
  endtask

  task automatic t_ignore(input logic [13:0] c1, input logic [13:0] c2);
    bit seen;
    int n0;
    n0 = cnv_rises;
    mdl_data = 16'h5A3C;
    kick(c1, 1'b0);
    while (sck_o) @(negedge clk);
    start_i = 1'b1; cfg_i = c2;
    @(negedge clk);
    start_i = 1'b0;
    wait_valid(seen);
    chk(seen, "R2 frame completes", seen, 1);
    repeat (20) @(negedge clk);
    chk(cnv_rises - n0 == 1, "R2 one conversion only", cnv_rises - n0, 1);
    chk(busy_o == 1'b0, "R2 idle after frame", busy_o, 0);
    chk(mdl_cfg == c1, "R2 config unchanged by ignored start", mdl_cfg, c1);
  endtask

  task automatic t_timeout;
    int n = 0, vseen = 0;
    mdl_on = 1'b0;
    kick(14'h1234, 1'b0);
    while (!err_o && n < LIMIT + 20) begin
      @(negedge clk);
      n++;
      if (result_valid_o) vseen++;
    end
    chk(err_o == 1'b1, "R4 timeout flag", err_o, 1);
    chk(n >= LIMIT - 1 && n <= LIMIT + 1, "R4 timeout latency", n, LIMIT);
    chk(busy_o == 1'b0, "R4 idle after timeout", busy_o, 0);
    chk(vseen == 0, "R4 no valid on timeout", vseen, 0);
    mdl_on = 1'b1;
    kick(14'h0F0F, 1'b0);
    chk(err_o == 1'b0, "R4 err cleared by start", err_o, 1'b0);
    begin
      bit seen;
      wait_valid(seen);
      chk(seen, "R4 recovers after timeout", seen, 1);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain(14'h2A55, 16'hB38E);
    t_plain(14'h3FFF, 16'h0001);
    t_readback(14'h1C07, 16'h8000);
    t_readback(14'h0001, 16'hFFFF);
    t_ignore(14'h0ABC, 14'h3333);
    t_timeout();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule